// File: doc/BRIEF.md
# Root Hub Port Status and Control Register Bank

This block holds the status and control word of each downstream port of a USB root hub. Software reaches the words over a simple 16-bit register bus: a write strobe with a port index and data, and a combinational read path picked by a separate read index. A port index at or beyond the number of built ports reads back a fixed pattern, and a write to such an index is dropped.

The device side enters through three signals per port. A one-cycle attach pulse and a one-cycle detach pulse mark device arrival and removal. A speed level reports whether the attached device is low speed. The block tracks connect state, the enable bit and the two change flags. The change flags are cleared by writing a 1 to them. When software moves the bus-reset bit from 0 to 1, the block raises a one-cycle reset request toward that port's device.

A controller-level reset input returns every word to zero. A port whose device is still present then shows a fresh connection.

Top module: `usb_rootport_regs`

## Requirements
- R1: After `rst`, every port word reads 0x0000 and no `bus_reset_req` bit is high.
- R2: A write to port i sets bit 2 (enable) and bits 15..9 of its word to the written value. Bits 8..3, 1 and 0 keep their old value, except as R3 allows.
- R3: After the merge in R2, bit 1 (connect change) and bit 3 (enable change) clear wherever the written data has a 1. A 0 written there leaves them unchanged.
- R4: A write that carries bit 9 = 1 to a port whose bit 9 is 0 raises that port's `bus_reset_req` for exactly one cycle, in the cycle after the write edge. A write of 1 while bit 9 is already 1 raises nothing.
- R5: On an attach pulse, if bit 0 (connected) is clear, bits 0 and 1 are set. In every case bit 8 takes the value of `dev_lowspeed`.
- R6: On a detach pulse, a set enable bit 2 clears and bit 3 is set. A set connect bit 0 clears and bit 1 is set.
- R7: Reading an index at or above NUM_PORTS returns 0xFF7F. A write to such an index changes no port word.
- R8: A cycle with `ctrl_reset` high clears every word and issues no reset request. In that cycle a port with a present device then gets bits 0 and 1 set and bit 8 loaded from `dev_lowspeed`. Attach and detach pulses in that cycle are ignored.
- R9: When a write, a detach and an attach hit one port in the same cycle, the write merge applies first, then the detach, then the attach.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_reset | input | 1 | Controller-level reset of all port words |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | IDXW | Port index of the write |
| wr_data | input | 16 | Write data |
| rd_idx | input | IDXW | Port index of the read |
| rd_data | output | 16 | Read data, combinational |
| dev_attach | input | NUM_PORTS | Device attach pulse per port |
| dev_detach | input | NUM_PORTS | Device detach pulse per port |
| dev_lowspeed | input | NUM_PORTS | Attached device is low speed, per port |
| bus_reset_req | output | NUM_PORTS | One-cycle bus reset request per port |

## Verification
The bench builds the block with the default of two ports. The index is then two bits wide, so indices 2 and 3 sit beyond the ports. Both absent-port reads and dropped writes are reachable on every random cycle. With two ports, the bench can also show that an event or write on one port leaves its neighbour alone, and the coincident write/detach/attach orderings occur often enough under random stimulus.

// File: rtl/usbport_pkg.sv
package usbport_pkg;

    localparam int REG_W    = 16;
    localparam int B_CONN   = 0;
    localparam int B_CONN_C = 1;
    localparam int B_EN     = 2;
    localparam int B_EN_C   = 3;
    localparam int B_LOWSPD = 8;
    localparam int B_BUSRST = 9;

    localparam logic [REG_W-1:0] KEEP_MASK  = 16'h01FB;
    localparam logic [REG_W-1:0] CLR1_MASK  = 16'h000A;
    localparam logic [REG_W-1:0] ABSENT_VAL = 16'hFF7F;

    typedef logic [REG_W-1:0] pword_t;

    typedef struct packed {
        logic   hit;
        pword_t data;
    } wr_req_t;

    typedef struct packed {
        logic attach;
        logic detach;
        logic lowspeed;
    } dev_evt_t;

    function automatic pword_t merge_write(pword_t cur, pword_t wd);
        pword_t v;
        v = (cur & KEEP_MASK) | (wd & ~KEEP_MASK);
        v = v & ~(wd & CLR1_MASK);
        return v;
    endfunction

    function automatic pword_t on_detach(pword_t cur);
        pword_t v;
        v = cur;
        if (v[B_EN]) begin
            v[B_EN]   = 1'b0;
            v[B_EN_C] = 1'b1;
        end
        if (v[B_CONN]) begin
            v[B_CONN]   = 1'b0;
            v[B_CONN_C] = 1'b1;
        end
        return v;
    endfunction

    function automatic pword_t on_attach(pword_t cur, logic ls);
        pword_t v;
        v = cur;
        if (!v[B_CONN]) begin
            v[B_CONN]   = 1'b1;
            v[B_CONN_C] = 1'b1;
        end
        v[B_LOWSPD] = ls;
        return v;
    endfunction

endpackage

// File: rtl/usbport_cell.sv
module usbport_cell
    import usbport_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     ctrl_reset,
    input  wr_req_t  wr,
    input  dev_evt_t evt,
    output pword_t   stat_q,
    output logic     rst_req
);

    logic   present_q;
    pword_t nxt;

    always_comb begin
        nxt = stat_q;
        if (wr.hit)
            nxt = merge_write(nxt, wr.data);
        if (evt.detach)
            nxt = on_detach(nxt);
        if (evt.attach)
            nxt = on_attach(nxt, evt.lowspeed);
        if (ctrl_reset)
            nxt = present_q ? on_attach('0, evt.lowspeed) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q    <= '0;
            present_q <= 1'b0;
            rst_req   <= 1'b0;
        end else begin
            stat_q  <= nxt;
            rst_req <= !ctrl_reset && wr.hit && wr.data[B_BUSRST] && !stat_q[B_BUSRST];
            if (!ctrl_reset) begin
                if (evt.attach)
                    present_q <= 1'b1;
                else if (evt.detach)
                    present_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/usbport_rdmux.sv
module usbport_rdmux
    import usbport_pkg::*;
#(
    parameter int NUM_PORTS = 2,
    parameter int IDXW      = 2
) (
    input  pword_t [NUM_PORTS-1:0] regs,
    input  logic   [IDXW-1:0]      rd_idx,
    output pword_t                 rd_data
);

    always_comb begin
        rd_data = ABSENT_VAL;
        for (int i = 0; i < NUM_PORTS; i++) begin
            if (rd_idx == IDXW'(i))
                rd_data = regs[i];
        end
    end

endmodule

// File: rtl/usb_rootport_regs.sv
module usb_rootport_regs
    import usbport_pkg::*;
#(
    parameter int  NUM_PORTS = 2,
    localparam int IDXW      = $clog2(NUM_PORTS) + 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ctrl_reset,
    input  logic                 wr_en,
    input  logic [IDXW-1:0]      wr_idx,
    input  logic [15:0]          wr_data,
    input  logic [IDXW-1:0]      rd_idx,
    output logic [15:0]          rd_data,
    input  logic [NUM_PORTS-1:0] dev_attach,
    input  logic [NUM_PORTS-1:0] dev_detach,
    input  logic [NUM_PORTS-1:0] dev_lowspeed,
    output logic [NUM_PORTS-1:0] bus_reset_req
);

    pword_t [NUM_PORTS-1:0] port_q;

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
        wr_req_t  wr;
        dev_evt_t evt;

        assign wr.hit       = wr_en && (wr_idx == IDXW'(g));
        assign wr.data      = wr_data;
        assign evt.attach   = dev_attach[g];
        assign evt.detach   = dev_detach[g];
        assign evt.lowspeed = dev_lowspeed[g];

        usbport_cell u_cell (
            .clk        (clk),
            .rst        (rst),
            .ctrl_reset (ctrl_reset),
            .wr         (wr),
            .evt        (evt),
            .stat_q     (port_q[g]),
            .rst_req    (bus_reset_req[g])
        );
    end

    usbport_rdmux #(
        .NUM_PORTS (NUM_PORTS),
        .IDXW      (IDXW)
    ) u_rdmux (
        .regs    (port_q),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/usbport_chk.sv
module usbport_chk
    import usbport_pkg::*;
#(
    parameter int NUM_PORTS = 2,
    parameter int IDXW      = 2
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   ctrl_reset,
    input logic                   wr_en,
    input logic [IDXW-1:0]        wr_idx,
    input logic [15:0]            wr_data,
    input logic [IDXW-1:0]        rd_idx,
    input logic [15:0]            rd_data,
    input logic [NUM_PORTS-1:0]   dev_attach,
    input logic [NUM_PORTS-1:0]   dev_detach,
    input logic [NUM_PORTS-1:0]   dev_lowspeed,
    input logic [NUM_PORTS-1:0]   bus_reset_req,
    input pword_t [NUM_PORTS-1:0] port_q
);

    localparam logic [IDXW-1:0] LAST_IDX = IDXW'(NUM_PORTS - 1);

    assert_absent_read_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_idx > LAST_IDX) |-> (rd_data == ABSENT_VAL));

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_chk
        assert_req_single_R4: assert property (@(posedge clk) disable iff (rst)
            bus_reset_req[g] |=> !bus_reset_req[g]);

        assert_req_cause_R4: assert property (@(posedge clk) disable iff (rst)
            $rose(bus_reset_req[g]) |-> $past(wr_en && wr_idx == IDXW'(g) && wr_data[B_BUSRST]));

        assert_attach_conn_R5: assert property (@(posedge clk) disable iff (rst)
            (dev_attach[g] && !ctrl_reset) |=>
                (port_q[g][B_CONN] && port_q[g][B_LOWSPD] == $past(dev_lowspeed[g])));

        assert_detach_disc_R6: assert property (@(posedge clk) disable iff (rst)
            (dev_detach[g] && !dev_attach[g] && !ctrl_reset) |=>
                (!port_q[g][B_CONN] && !port_q[g][B_EN]));

        assert_ctrl_reset_R8: assert property (@(posedge clk) disable iff (rst)
            ctrl_reset |=> (!port_q[g][B_EN] && !port_q[g][B_BUSRST] && !bus_reset_req[g]));

        assert_enable_by_write_R2: assert property (@(posedge clk) disable iff (rst)
            $rose(port_q[g][B_EN]) |-> $past(wr_en && wr_idx == IDXW'(g) && wr_data[B_EN]));
    end

endmodule

bind usb_rootport_regs usbport_chk #(
    .NUM_PORTS (NUM_PORTS),
    .IDXW      (IDXW)
) u_chk (.*);

// File: tb/tb_usb_rootport_regs.sv
module tb_usb_rootport_regs;

    localparam int NUM  = 2;
    localparam int IDXW = $clog2(NUM) + 1;

    logic            clk = 1'b0;
    logic            rst;
    logic            ctrl_reset;
    logic            wr_en;
    logic [IDXW-1:0] wr_idx;
    logic [15:0]     wr_data;
    logic [IDXW-1:0] rd_idx;
    logic [15:0]     rd_data;
    logic [NUM-1:0]  dev_attach, dev_detach, dev_lowspeed, bus_reset_req;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [15:0]    m_reg [NUM];
    logic [NUM-1:0] m_pres;

    always #10 clk = ~clk;

    usb_rootport_regs #(.NUM_PORTS(NUM)) dut (
        .clk(clk), .rst(rst), .ctrl_reset(ctrl_reset), .wr_en(wr_en),
        .wr_idx(wr_idx), .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data),
        .dev_attach(dev_attach), .dev_detach(dev_detach),
        .dev_lowspeed(dev_lowspeed), .bus_reset_req(bus_reset_req)
    );

    function automatic logic [15:0] f_write(logic [15:0] c, logic [15:0] d);
        logic [15:0] v;
        v = (c & 16'h01FB) | (d & 16'hFE04);
        return v & ~(d & 16'h000A);
    endfunction

    function automatic logic [15:0] f_detach(logic [15:0] c);
        logic [15:0] v = c;
        if (v[2]) begin v[2] = 0; v[3] = 1; end
        if (v[0]) begin v[0] = 0; v[1] = 1; end
        return v;
    endfunction

    function automatic logic [15:0] f_attach(logic [15:0] c, logic ls);
        logic [15:0] v = c;
        if (!v[0]) begin v[0] = 1; v[1] = 1; end
        v[8] = ls;
        return v;
    endfunction

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
        end
    endtask

    task automatic idle();
        wr_en = 0; ctrl_reset = 0; dev_attach = '0; dev_detach = '0;
    endtask

    task automatic check_all(string tag, logic [NUM-1:0] exp_req);
        check({tag, " R4 req"}, 16'(bus_reset_req), 16'(exp_req));
        for (int k = 0; k < (1 << IDXW); k++) begin
            rd_idx = IDXW'(k);
            #1;
            if (k < NUM) check({tag, " word"}, rd_data, m_reg[k]);
            else         check({tag, " R7 absent"}, rd_data, 16'hFF7F);
        end
    endtask

    task automatic cycle(string tag);
        logic [NUM-1:0] exp_req;
        for (int i = 0; i < NUM; i++) begin
            logic hit;
            logic [15:0] v;
            hit = wr_en && (wr_idx == IDXW'(i));
            exp_req[i] = !ctrl_reset && hit && wr_data[9] && !m_reg[i][9];
            v = m_reg[i];
            if (ctrl_reset) begin
                v = m_pres[i] ? f_attach(16'h0, dev_lowspeed[i]) : 16'h0;
            end else begin
                if (hit) v = f_write(v, wr_data);
                if (dev_detach[i]) v = f_detach(v);
                if (dev_attach[i]) v = f_attach(v, dev_lowspeed[i]);
                if (dev_attach[i]) m_pres[i] = 1;
                else if (dev_detach[i]) m_pres[i] = 0;
            end
            m_reg[i] = v;
        end
        @(posedge clk);
        @(negedge clk);
        idle();
        check_all(tag, exp_req);
    endtask

    task automatic wr(int idx, logic [15:0] d, string tag);
        wr_en = 1; wr_idx = IDXW'(idx); wr_data = d;
        cycle(tag);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0017));
        idle();
        rst = 1; wr_idx = '0; wr_data = '0; rd_idx = '0; dev_lowspeed = '0;
        for (int i = 0; i < NUM; i++) m_reg[i] = 16'h0;
        m_pres = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        check_all("R1 reset", '0);

        // R2 + R4: all ones to port 0, no device
        wr(0, 16'hFFFF, "R2 R4 first");
        check("R2 direct", m_reg[0], 16'hFE04);
        wr(0, 16'hFFFF, "R4 held");
        wr(0, 16'h0000, "R2 clear");
        wr(0, 16'h0200, "R4 again");
        // R7: write to absent index changes nothing
        wr(3, 16'hFFFF, "R7 absent write");
        // R5: attach low speed device on port 1
        dev_lowspeed[1] = 1; dev_attach[1] = 1;
        cycle("R5 attach");
        check("R5 direct", m_reg[1], 16'h0103);
        // R3: clear connect change
        wr(1, 16'h0002, "R3 clear change");
        check("R3 direct", m_reg[1], 16'h0101);
        wr(1, 16'h0004, "R2 enable");
        // R6: detach
        dev_detach[1] = 1;
        cycle("R6 detach");
        check("R6 direct", m_reg[1], 16'h010A);
        // R9: write + detach + attach same cycle
        dev_attach[0] = 1; dev_lowspeed[0] = 0;
        cycle("R5 attach p0");
        wr_en = 1; wr_idx = 0; wr_data = 16'h000E;
        dev_detach[0] = 1; dev_attach[0] = 1;
        cycle("R9 order");
        // R8: controller reset with port 0 present, port 1 absent
        ctrl_reset = 1; dev_lowspeed = 2'b01; dev_attach[1] = 1;
        cycle("R8 ctrl reset");
        check("R8 direct", m_reg[0], 16'h0103);

        for (int n = 0; n < 3000; n++) begin
            int r = $urandom_range(0, 99);
            wr_en   = ($urandom_range(0, 2) == 0);
            wr_idx  = IDXW'($urandom_range(0, (1 << IDXW) - 1));
            wr_data = 16'($urandom());
            for (int i = 0; i < NUM; i++) begin
                dev_attach[i]   = ($urandom_range(0, 9) == 0);
                dev_detach[i]   = ($urandom_range(0, 9) == 0);
                dev_lowspeed[i] = 1'($urandom_range(0, 1));
            end
            ctrl_reset = (r < 3);
            cycle("R2 R3 R5 R6 R9 random");
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule